// File: doc/BRIEF.md
# Dual 8-bit Timer Control and Status Register

This block is the single byte of control and status that sits beside a pair of 8-bit up-counters, called the high half and the low half, each of which has its own output-compare value. For each half it keeps an overflow flag, a compare-match flag, an overflow-interrupt enable and a clear-on-match select. The counters report their events to it as one-cycle pulses. It returns a clear request to each counter and raises an overflow interrupt request per half.

Software sees the byte through a simple read/write port. The two flags of each half are set only by hardware. A flag is cleared only by the following sequence: software first reads the flag as 1, and its next write then puts a 0 in that flag's bit position. Writing a 1 to a flag bit never sets it. Each flag has a private "seen as 1" latch. A register read arms that latch while the flag is 1, and the next write always disarms it, whether or not that write clears the flag.

Top module: `tmr_pair_csr`

## Requirements
- R1: While reset is asserted and right after it, the register reads 0x00, and both interrupt requests and both clear requests are low.
- R2: The read data is always the register byte, laid out as bit 7 = high overflow flag, bit 6 = high compare flag, bit 5 = high overflow-interrupt enable, bit 4 = high clear-on-match select, bit 3 = low overflow flag, bit 2 = low compare flag, bit 1 = low overflow-interrupt enable, bit 0 = low clear-on-match select. A write loads bits 5, 4, 1 and 0 directly from the write data.
- R3: An overflow pulse from a half sets that half's overflow flag (bit 7 high, bit 3 low), and the flag is visible in the cycle after the pulse.
- R4: A compare-match pulse from a half sets that half's compare flag (bit 6 high, bit 2 low), and the flag is visible in the cycle after the pulse.
- R5: A written 1 in a flag bit position (7, 6, 3, 2) never sets a clear flag.
- R6: A write with 0 in a flag's bit position clears that flag only if a read was made while the flag was 1, with no write in between. A write with no such read, or after a read made while the flag was 0, leaves the flag set.
- R7: Every write disarms all four read latches, including a write that puts 1 in the flag bit. A write that comes in the same cycle as a read also disarms them.
- R8: If a hardware set pulse arrives in the same cycle as a write that would clear the flag, the flag stays 1.
- R9: Each half's overflow interrupt request is high exactly while its overflow flag and its overflow-interrupt enable are both 1. The request stays high as a level until the flag is cleared or the enable is written to 0.
- R10: A half's clear request is high in the same cycle as its compare-match pulse when its clear-on-match select is 1, and low otherwise. The counter then returns to 0x00 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | Register read strobe, one cycle per read |
| cpu_wr | input | 1 | Register write strobe, one cycle per write |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Current register byte |
| hi_ovf_evt | input | 1 | High counter wrapped from 0xFF to 0x00 (pulse) |
| hi_cmp_evt | input | 1 | High counter equals its compare value (pulse) |
| lo_ovf_evt | input | 1 | Low counter wrapped from 0xFF to 0x00 (pulse) |
| lo_cmp_evt | input | 1 | Low counter equals its compare value (pulse) |
| hi_clr_req | output | 1 | Clear request to the high counter |
| lo_clr_req | output | 1 | Clear request to the low counter |
| hi_ovf_irq | output | 1 | High overflow interrupt request (level) |
| lo_ovf_irq | output | 1 | Low overflow interrupt request (level) |

## Verification
The bench targets the clearing handshake. It checks a write of 0 without a prior read, which a design that ignored the latch would clear. It checks a read taken while the flag was still 0, which an armed-anyway latch would wrongly honour. It also checks a write of 1 between the read and the clearing write, which a design that failed to disarm would let clear the flag. It drives a set pulse into the very cycle of a clearing write, where a clear-priority design would drop the event. It runs free counters with random reads, writes and event pulses against a behavioural model to catch clear requests that miss the match cycle or ignore the select bit.

// File: rtl/tmr_pair_csr.sv
module tmr_pair_csr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_rd,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  input  logic       hi_ovf_evt,
  input  logic       hi_cmp_evt,
  input  logic       lo_ovf_evt,
  input  logic       lo_cmp_evt,
  output logic       hi_clr_req,
  output logic       lo_clr_req,
  output logic       hi_ovf_irq,
  output logic       lo_ovf_irq
);

  logic [1:0] ovf_q, cmp_q, ovf_seen, cmp_seen, ien_q, csel_q;
  logic [1:0] ovf_ev, cmp_ev;

  assign ovf_ev = {hi_ovf_evt, lo_ovf_evt};
  assign cmp_ev = {hi_cmp_evt, lo_cmp_evt};

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam int B = 4 * h;

    logic ovf_kill, cmp_kill;
    assign ovf_kill = cpu_wr && ovf_seen[h] && !cpu_wdata[B+3];
    assign cmp_kill = cpu_wr && cmp_seen[h] && !cpu_wdata[B+2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ovf_q[h]    <= 1'b0;
        cmp_q[h]    <= 1'b0;
        ovf_seen[h] <= 1'b0;
        cmp_seen[h] <= 1'b0;
        ien_q[h]    <= 1'b0;
        csel_q[h]   <= 1'b0;
      end else begin
        ovf_q[h] <= ovf_ev[h] | (ovf_q[h] & ~ovf_kill);
        cmp_q[h] <= cmp_ev[h] | (cmp_q[h] & ~cmp_kill);
        if (cpu_wr) begin
          ovf_seen[h] <= 1'b0;
          cmp_seen[h] <= 1'b0;
          ien_q[h]    <= cpu_wdata[B+1];
          csel_q[h]   <= cpu_wdata[B];
        end else if (cpu_rd) begin
          ovf_seen[h] <= ovf_seen[h] | ovf_q[h];
          cmp_seen[h] <= cmp_seen[h] | cmp_q[h];
        end
      end
    end

    assign cpu_rdata[B+3:B] = {ovf_q[h], cmp_q[h], ien_q[h], csel_q[h]};
  end

  assign hi_ovf_irq = ovf_q[1] & ien_q[1];
  assign lo_ovf_irq = ovf_q[0] & ien_q[0];
  assign hi_clr_req = csel_q[1] & cmp_ev[1];
  assign lo_clr_req = csel_q[0] & cmp_ev[0];

endmodule

// File: rtl/tmr_pair_csr_chk.sv
module tmr_pair_csr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_rd,
  input logic       cpu_wr,
  input logic [7:0] cpu_wdata,
  input logic [7:0] cpu_rdata,
  input logic       hi_ovf_evt,
  input logic       hi_cmp_evt,
  input logic       lo_ovf_evt,
  input logic       lo_cmp_evt,
  input logic       hi_clr_req,
  input logic       lo_clr_req,
  input logic       hi_ovf_irq,
  input logic       lo_ovf_irq
);

  always @(negedge clk) begin
    if (!rst_n) a_r1_reset_zero: assert (cpu_rdata == 8'h00 && !hi_ovf_irq && !lo_ovf_irq);
  end

  a_r3_hi_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ovf_evt |=> cpu_rdata[7]);
  a_r3_lo_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    lo_ovf_evt |=> cpu_rdata[3]);
  a_r4_hi_cmp_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cmp_evt |=> cpu_rdata[6]);
  a_r4_lo_cmp_sets: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cmp_evt |=> cpu_rdata[2]);
  a_r5_no_sw_set_hi: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rdata[7] && !hi_ovf_evt |=> !cpu_rdata[7]);
  a_r5_no_sw_set_lo: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rdata[2] && !lo_cmp_evt |=> !cpu_rdata[2]);
  a_r6_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[3] && !cpu_wr |=> cpu_rdata[3]);
  a_r9_irq_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ovf_irq && !cpu_wr |=> hi_ovf_irq);
  a_r10_hi_clr_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    hi_clr_req |-> hi_cmp_evt);
  a_r10_lo_clr_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    lo_clr_req |-> lo_cmp_evt);

endmodule

bind tmr_pair_csr tmr_pair_csr_chk u_chk (.*);

// File: tb/sim_tmr_pair_csr.sv
`timescale 1ns/1ps
module sim_tmr_pair_csr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic f_hov = 0, f_hcm = 0, f_lov = 0, f_lcm = 0;
  logic c_hov = 0, c_hcm = 0, c_lov = 0, c_lcm = 0;
  logic hi_ovf_evt, hi_cmp_evt, lo_ovf_evt, lo_cmp_evt;
  logic hi_clr_req, lo_clr_req, hi_ovf_irq, lo_ovf_irq;
  logic tick = 1'b0;
  logic [7:0] cnt_h = 0, cnt_l = 0, ocr_h = 8'h05, ocr_l = 8'hF0;
  int vectors = 0, miscompares = 0, cycles = 0;
  logic [7:0] mreg = 0, marm = 0;
  bit done = 0, over_h = 0;

  always #10 clk = ~clk;

  assign hi_ovf_evt = f_hov | c_hov;
  assign hi_cmp_evt = f_hcm | c_hcm;
  assign lo_ovf_evt = f_lov | c_lov;
  assign lo_cmp_evt = f_lcm | c_lcm;

  tmr_pair_csr u0 (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_h <= 0; cnt_l <= 0;
      c_hov <= 0; c_hcm <= 0; c_lov <= 0; c_lcm <= 0;
    end else begin
      c_hov <= tick && cnt_h == 8'hFF && !hi_clr_req;
      c_lov <= tick && cnt_l == 8'hFF && !lo_clr_req;
      c_hcm <= tick && !hi_clr_req && 8'(cnt_h + 1) == ocr_h;
      c_lcm <= tick && !lo_clr_req && 8'(cnt_l + 1) == ocr_l;
      if (hi_clr_req) cnt_h <= 0; else if (tick) cnt_h <= cnt_h + 1;
      if (lo_clr_req) cnt_l <= 0; else if (tick) cnt_l <= cnt_l + 1;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mreg = 0; marm = 0;
    end else begin
      logic [7:0] ev, nr, na;
      ev = {hi_ovf_evt, hi_cmp_evt, 2'b00, lo_ovf_evt, lo_cmp_evt, 2'b00};
      for (int b = 0; b < 8; b++) begin
        if (b == 7 || b == 6 || b == 3 || b == 2) begin
          nr[b] = ev[b] | (mreg[b] & !(cpu_wr && marm[b] && !cpu_wdata[b]));
          na[b] = cpu_wr ? 1'b0 : ((cpu_rd && mreg[b]) ? 1'b1 : marm[b]);
        end else begin
          nr[b] = cpu_wr ? cpu_wdata[b] : mreg[b];
          na[b] = 1'b0;
        end
      end
      mreg = nr; marm = na;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always begin
    @(negedge clk); #5;
    if (rst_n && !done) begin
      chk("R2 model rdata", cpu_rdata, mreg);
      chk("R9 model hi irq", hi_ovf_irq, mreg[7] & mreg[5]);
      chk("R9 model lo irq", lo_ovf_irq, mreg[3] & mreg[1]);
      chk("R10 model hi clr", hi_clr_req, mreg[4] & hi_cmp_evt);
      chk("R10 model lo clr", lo_clr_req, mreg[0] & lo_cmp_evt);
      if (tick && mreg[4] && cnt_h > ocr_h) over_h = 1;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic rd();
    cpu_rd = 1; @(negedge clk); cpu_rd = 0;
  endtask
  task automatic wr(input logic [7:0] d);
    cpu_wr = 1; cpu_wdata = d; @(negedge clk); cpu_wr = 0;
  endtask
  task automatic pulse(input int which);
    case (which)
      0: f_hov = 1; 1: f_hcm = 1; 2: f_lov = 1; default: f_lcm = 1;
    endcase
    @(negedge clk);
    f_hov = 0; f_hcm = 0; f_lov = 0; f_lcm = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", cpu_rdata, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {cpu_rdata, hi_ovf_irq, lo_ovf_irq, hi_clr_req, lo_clr_req}, 12'h000);
    wr(8'hFF);  chk("R5 write ones keeps flags clear, R2 controls", cpu_rdata, 8'h33);
    wr(8'h00);  chk("R2 control bits cleared", cpu_rdata, 8'h00);
    pulse(0);   chk("R3 hi overflow flag", cpu_rdata, 8'h80);
    pulse(2);   chk("R3 lo overflow flag", cpu_rdata, 8'h88);
    pulse(1);   chk("R4 hi compare flag", cpu_rdata, 8'hC8);
    pulse(3);   chk("R4 lo compare flag", cpu_rdata, 8'hCC);
    wr(8'h00);  chk("R6 no read so no clear", cpu_rdata, 8'hCC);
    rd(); wr(8'h00); chk("R6 read then write clears", cpu_rdata, 8'h00);
    rd(); pulse(2); wr(8'h00);
    chk("R6 read while clear does not arm", cpu_rdata, 8'h08);
    rd(); wr(8'h08); chk("R7 write of one keeps flag", cpu_rdata, 8'h08);
    wr(8'h00);  chk("R7 latch consumed by prior write", cpu_rdata, 8'h08);
    rd();
    f_lov = 1; cpu_wr = 1; cpu_wdata = 8'h00; @(negedge clk);
    f_lov = 0; cpu_wr = 0;
    chk("R8 set wins over clear", cpu_rdata, 8'h08);
    rd(); wr(8'h00); chk("R8 then clearable", cpu_rdata, 8'h00);
    wr(8'h22);  chk("R9 irq low without flag", {hi_ovf_irq, lo_ovf_irq}, 2'b00);
    pulse(0);   chk("R9 hi irq raised", {hi_ovf_irq, lo_ovf_irq}, 2'b10);
    repeat (4) @(negedge clk);
    chk("R9 hi irq held as level", hi_ovf_irq, 1);
    rd(); wr(8'h22); chk("R9 irq drops on clear", {hi_ovf_irq, cpu_rdata}, 9'h022);
    pulse(2);   chk("R9 lo irq raised", lo_ovf_irq, 1);
    wr(8'h20);  chk("R9 lo irq off by enable", {lo_ovf_irq, cpu_rdata}, 9'h028);
    rd(); wr(8'h00);
    wr(8'h10);
    f_hcm = 1; f_lcm = 1; #5;
    chk("R10 clr follows select", {hi_clr_req, lo_clr_req}, 2'b10);
    @(negedge clk); f_hcm = 0; f_lcm = 0;
    rd(); wr(8'h11);
    tick = 1;
    repeat (60) @(negedge clk);
    chk("R10 counter kept at or below compare", over_h, 0);
    for (int i = 0; i < 3000; i++) begin
      cpu_rd = ($urandom % 3) == 0;
      cpu_wr = ($urandom % 5) == 0;
      cpu_wdata = 8'($urandom);
      f_hov = ($urandom % 23) == 0;
      f_lcm = ($urandom % 19) == 0;
      if (i % 500 == 0) begin
        ocr_h = 8'($urandom); ocr_l = 8'($urandom);
      end
      @(negedge clk);
    end
    cpu_rd = 0; cpu_wr = 0; f_hov = 0; f_lcm = 0;
    @(negedge clk);
    finish_run();
  end
endmodule